// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is a slave-only two-wire serial port. An external bus master uses it to read and write a bank of 8-bit control registers. The SCL and SDA pins are oversampled by a system clock that runs at least 16 times faster than SCL. The block watches the synchronized lines for start, repeated-start and stop conditions. It compares the calling address with a fixed 7-bit device address and acknowledges only on a match. It then captures a register sub-address and at most one data byte.

The register bank sits outside the block, behind a plain port: address, write data, a one-cycle write strobe and combinational read data. Each start/stop exchange touches one register only. To read, the master first writes the sub-address. It then issues a repeated start with the read bit set, and the block shifts the addressed register out, MSB first. The block never pulls SDA high: the output enable asks the pad to pull the line low.

Top module: `tws_reg_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and `reg_we` is 0.
- R2: A first byte whose bits 7:1 equal the device address 0110011 (bit 0 is the direction, 1 = read) is acknowledged: SDA is low during the 9th SCL high phase.
- R3: A first byte with any other address gets no acknowledge. SDA stays released for the rest of that exchange, and no register is written.
- R4: In a write-direction exchange, the byte after the address is the sub-address and the next byte is the data. Both are acknowledged, and exactly one `reg_we` pulse carries that sub-address and that data.
- R5: A third byte in a write exchange is not acknowledged and causes no write strobe.
- R6: After a repeated start with the read bit set, the block sends the register at the stored sub-address, MSB first, one bit per SCL pulse.
- R7: After the read byte, the block releases SDA and ignores whether the master acknowledges. It then waits for a start or stop.
- R8: A stop at any point, including in the middle of a byte, returns the block to idle without a write. The next exchange works normally.
- R9: `sda_oe` changes only while the synchronized SCL is low. It is 0 whenever the master is driving address or data bits, and whenever the block is idle.
- R10: The sub-address survives a repeated start, so different registers can each be read back through a write-sub-address-then-read sequence.
- R11: `reg_we` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level (wired-AND bus) |
| sda_oe | output | 1 | 1 = pull SDA low |
| reg_addr | output | ADDR_W | Register address (stored sub-address) |
| reg_wdata | output | DATA_W | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | DATA_W | Read data for `reg_addr` |

## Verification
Each pin passes through two synchronizer flops and one edge register. As a result, the block reacts to an SCL edge about three system clocks after the edge on the pin. Changes on `sda_oe` and the `reg_we` pulse follow the falling SCL edge that ends the 8th or 9th bit by that same delay. The bench drives every SDA change five clocks into an SCL low phase. It samples the acknowledge and read bits five clocks into the SCL high phase, well clear of that latency. A per-clock monitor matches every write strobe against a queue of expected writes. The same monitor flags any drive by the block while the master owns the line.

// File: rtl/tws_pkg.sv
package tws_pkg;
   localparam int TWS_BYTE_W = 8;
   localparam int TWS_LINES  = 2;
   localparam int LINE_SCL   = 0;
   localparam int LINE_SDA   = 1;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_DEV,
      ST_SUB,
      ST_ACK_SUB,
      ST_WDATA,
      ST_ACK_WR,
      ST_TX,
      ST_HOLD
   } tws_state_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync
   import tws_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [TWS_LINES-1:0] raw,
   output logic [TWS_LINES-1:0] lvl,
   output logic [TWS_LINES-1:0] prev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tws_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < TWS_LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain   <= '1;
            prev[g] <= 1'b1;
         end else begin
            chain   <= {chain[STAGES-2:0], raw[g]};
            prev[g] <= chain[STAGES-1];
         end
      end
      assign lvl[g] = chain[STAGES-1];
   end
endmodule

// File: rtl/tws_cond.sv
module tws_cond
   import tws_pkg::*;
(
   input  logic [TWS_LINES-1:0] lvl,
   input  logic [TWS_LINES-1:0] prev,
   output logic                 scl_hi,
   output logic                 sda_hi,
   output logic                 scl_rise,
   output logic                 scl_fall,
   output logic                 bus_start,
   output logic                 bus_stop
);
   logic scl_steady_hi;

   always_comb begin
      scl_hi        = lvl[LINE_SCL];
      sda_hi        = lvl[LINE_SDA];
      scl_rise      = lvl[LINE_SCL] & ~prev[LINE_SCL];
      scl_fall      = ~lvl[LINE_SCL] & prev[LINE_SCL];
      scl_steady_hi = lvl[LINE_SCL] & prev[LINE_SCL];
      bus_start     = scl_steady_hi & prev[LINE_SDA] & ~lvl[LINE_SDA];
      bus_stop      = scl_steady_hi & ~prev[LINE_SDA] & lvl[LINE_SDA];
   end
endmodule

// File: rtl/tws_fsm.sv
module tws_fsm
   import tws_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 8,
   parameter logic [6:0]  DEV_ADDR = 7'b0110011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_hi,
   input  logic              sda_hi,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              bus_start,
   input  logic              bus_stop,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [DATA_W-1:0] reg_rdata
);
   localparam int CNT_W = $clog2(TWS_BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(TWS_BYTE_W);

   if (DATA_W != TWS_BYTE_W) begin : g_bad_dw
      $error("tws_fsm: DATA_W must equal the bus byte width");
   end
   if (ADDR_W < 1 || ADDR_W > TWS_BYTE_W) begin : g_bad_aw
      $error("tws_fsm: ADDR_W must be 1..8");
   end

   tws_state_e                st;
   logic [CNT_W-1:0]          bitcnt;
   logic [TWS_BYTE_W-1:0]     shreg;
   logic [TWS_BYTE_W-1:0]     txsh;
   logic [TWS_BYTE_W-1:0]     sub;
   logic                      rw;
   logic                      byte_done;

   assign byte_done = scl_fall && (bitcnt == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         bitcnt    <= '0;
         shreg     <= '0;
         txsh      <= '0;
         sub       <= '0;
         rw        <= 1'b0;
         sda_oe    <= 1'b0;
         reg_we    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_we <= 1'b0;
         if (bus_stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (bus_start) begin
            st     <= ST_ADDR;
            sda_oe <= 1'b0;
            bitcnt <= '0;
         end else begin
            case (st)
               ST_ADDR, ST_SUB, ST_WDATA: begin
                  if (scl_rise && bitcnt != LAST_BIT) begin
                     shreg  <= {shreg[TWS_BYTE_W-2:0], sda_hi};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (byte_done) begin
                     bitcnt <= '0;
                     if (st == ST_ADDR) begin
                        if (shreg[TWS_BYTE_W-1:1] == DEV_ADDR) begin
                           sda_oe <= 1'b1;
                           rw     <= shreg[0];
                           st     <= ST_ACK_DEV;
                        end else begin
                           st <= ST_HOLD;
                        end
                     end else if (st == ST_SUB) begin
                        sub    <= shreg;
                        sda_oe <= 1'b1;
                        st     <= ST_ACK_SUB;
                     end else begin
                        reg_wdata <= shreg;
                        reg_we    <= 1'b1;
                        sda_oe    <= 1'b1;
                        st        <= ST_ACK_WR;
                     end
                  end
               end
               ST_ACK_DEV: begin
                  if (scl_fall) begin
                     if (rw) begin
                        sda_oe <= ~reg_rdata[TWS_BYTE_W-1];
                        txsh   <= {reg_rdata[TWS_BYTE_W-2:0], 1'b0};
                        st     <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_SUB;
                     end
                  end
               end
               ST_ACK_SUB: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     st     <= ST_WDATA;
                  end
               end
               ST_ACK_WR: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     st     <= ST_HOLD;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (byte_done) begin
                     sda_oe <= 1'b0;
                     bitcnt <= '0;
                     st     <= ST_HOLD;
                  end else if (scl_fall) begin
                     sda_oe <= ~txsh[TWS_BYTE_W-1];
                     txsh   <= {txsh[TWS_BYTE_W-2:0], 1'b0};
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign reg_addr = sub[ADDR_W-1:0];

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_hi) else $error("oe moved while SCL high"); // R9

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe) else $error("driving while idle"); // R9

   AST_NO_ACK_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADDR && byte_done && !bus_start && !bus_stop &&
       shreg[TWS_BYTE_W-1:1] != DEV_ADDR) |=> !sda_oe) else $error("ack on mismatch"); // R3

   AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we) else $error("write strobe longer than one cycle"); // R11

   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> (st == ST_IDLE && !sda_oe && !reg_we)) else $error("stop not honoured"); // R8

   AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD) |-> !sda_oe) else $error("driving in hold"); // R7
endmodule

// File: rtl/tws_reg_slave.sv
module tws_reg_slave
   import tws_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b0110011,
   parameter int         ADDR_W      = 8,
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [DATA_W-1:0] reg_rdata
);
   logic [TWS_LINES-1:0] raw_lines;
   logic [TWS_LINES-1:0] lvl_lines;
   logic [TWS_LINES-1:0] prev_lines;
   logic scl_hi, sda_hi, scl_rise, scl_fall, bus_start, bus_stop;

   always_comb begin
      raw_lines           = '1;
      raw_lines[LINE_SCL] = scl_i;
      raw_lines[LINE_SDA] = sda_i;
   end

   tws_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_lines),
      .lvl  (lvl_lines),
      .prev (prev_lines)
   );

   tws_cond u_cond (
      .lvl      (lvl_lines),
      .prev     (prev_lines),
      .scl_hi   (scl_hi),
      .sda_hi   (sda_hi),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .bus_start(bus_start),
      .bus_stop (bus_stop)
   );

   tws_fsm #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .DEV_ADDR(DEV_ADDR)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_hi   (scl_hi),
      .sda_hi   (sda_hi),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .bus_start(bus_start),
      .bus_stop (bus_stop),
      .sda_oe   (sda_oe),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_we   (reg_we),
      .reg_rdata(reg_rdata)
   );
endmodule

// File: tb/tb_tws_reg_slave.sv
module tb_tws_reg_slave;
   localparam logic [6:0] DEV = 7'b0110011;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       sda_oe;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic       reg_we;
   wire        sda_bus = m_sda & ~sda_oe;

   logic [7:0] regs [256];
   logic [7:0] exp_regs [256];
   logic [15:0] wq [$];
   int checks = 0, fails = 0, drive_viol = 0, wr_err = 0;
   bit master_drv = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tws_reg_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata)
   );

   assign reg_rdata = regs[reg_addr];

   initial begin
      for (int i = 0; i < 256; i++) begin
         regs[i]     = 8'(i * 7 + 3);
         exp_regs[i] = 8'(i * 7 + 3);
      end
   end

   always @(posedge clk) if (reg_we) regs[reg_addr] <= reg_wdata;

   // per-clock reference comparison
   always @(negedge clk) begin
      if (rst_n) begin
         if (master_drv && sda_oe) drive_viol++;
         if (reg_we) begin
            if (wq.size() == 0) wr_err++;
            else begin
               logic [15:0] e;
               e = wq.pop_front();
               if ({reg_addr, reg_wdata} != e) wr_err++;
            end
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_start();
      m_scl = 1'b0; master_drv = 1'b0; tick(5);
      m_sda = 1'b1; tick(5);
      m_scl = 1'b1; tick(5);
      m_sda = 1'b0; tick(5);
   endtask

   task automatic do_stop();
      m_scl = 1'b0; master_drv = 1'b0; tick(5);
      m_sda = 1'b0; tick(5);
      m_scl = 1'b1; tick(5);
      m_sda = 1'b1; tick(10);
   endtask

   task automatic bit_wr(logic b);
      m_scl = 1'b0; master_drv = 1'b0; tick(5);
      m_sda = b; master_drv = 1'b1; tick(5);
      m_scl = 1'b1; tick(10);
   endtask

   task automatic bit_rd(output logic b);
      m_scl = 1'b0; master_drv = 1'b0; tick(5);
      m_sda = 1'b1; tick(5);
      m_scl = 1'b1; tick(5);
      b = sda_bus; tick(5);
   endtask

   task automatic byte_wr(logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_wr(b[i]);
      bit_rd(s);
      ack = ~s;
   endtask

   task automatic byte_rd(output logic [7:0] b, input logic master_ack);
      for (int i = 7; i >= 0; i--) bit_rd(b[i]);
      bit_wr(~master_ack);
   endtask

   task automatic wr_reg(logic [7:0] sub, logic [7:0] d, string req);
      logic a;
      do_start();
      byte_wr({DEV, 1'b0}, a); chk("R2", 8'(a), 8'd1, "address ack");
      byte_wr(sub, a);         chk(req, 8'(a), 8'd1, "sub-address ack");
      byte_wr(d, a);           chk(req, 8'(a), 8'd1, "data ack");
      do_stop();
      exp_regs[sub] = d;
   endtask

   task automatic rd_reg(logic [7:0] sub, logic mack, output logic [7:0] d);
      logic a;
      do_start();
      byte_wr({DEV, 1'b0}, a); chk("R2", 8'(a), 8'd1, "address ack (read setup)");
      byte_wr(sub, a);         chk("R10", 8'(a), 8'd1, "sub-address ack (read setup)");
      do_start();
      byte_wr({DEV, 1'b1}, a); chk("R6", 8'(a), 8'd1, "read address ack");
      byte_rd(d, mack);
   endtask

   initial begin
      logic a;
      logic [7:0] d;
      tick(4);
      chk("R1", 8'(sda_oe), 8'd0, "sda_oe in reset");
      chk("R1", 8'(reg_we), 8'd0, "reg_we in reset");
      rst_n = 1'b1;
      tick(10);
      chk("R1", 8'(sda_oe), 8'd0, "sda_oe after reset");

      // R4: two writes
      wq.push_back({8'h12, 8'hA5});
      wr_reg(8'h12, 8'hA5, "R4");
      wq.push_back({8'h40, 8'h3C});
      wr_reg(8'h40, 8'h3C, "R4");
      chk("R4", regs[8'h12], 8'hA5, "register 0x12 after write");
      chk("R4", regs[8'h40], 8'h3C, "register 0x40 after write");

      // R6/R7: read with master NACK
      rd_reg(8'h12, 1'b0, d);
      chk("R6", d, exp_regs[8'h12], "read data 0x12");
      bit_rd(a); chk("R7", 8'(a), 8'd1, "SDA released after read byte");
      do_stop();

      // R3: wrong address
      do_start();
      byte_wr(8'hAA, a); chk("R3", 8'(a), 8'd0, "no ack on mismatch");
      byte_wr(8'h12, a); chk("R3", 8'(a), 8'd0, "no ack on later byte");
      byte_wr(8'h00, a); chk("R3", 8'(a), 8'd0, "no ack on data byte");
      do_stop();
      chk("R3", regs[8'h12], 8'hA5, "register untouched after mismatch");

      // R5: third byte
      wq.push_back({8'h40, 8'h11});
      do_start();
      byte_wr({DEV, 1'b0}, a); chk("R2", 8'(a), 8'd1, "address ack");
      byte_wr(8'h40, a);
      byte_wr(8'h11, a);       chk("R4", 8'(a), 8'd1, "data ack");
      byte_wr(8'h22, a);       chk("R5", 8'(a), 8'd0, "third byte not acked");
      do_stop();
      exp_regs[8'h40] = 8'h11;
      chk("R5", regs[8'h40], 8'h11, "third byte not written");

      // R8: stop in the middle of the data byte
      do_start();
      byte_wr({DEV, 1'b0}, a);
      byte_wr(8'h12, a);
      bit_wr(1'b0); bit_wr(1'b1); bit_wr(1'b1); bit_wr(1'b0);
      do_stop();
      chk("R8", regs[8'h12], 8'hA5, "aborted byte not written");
      chk("R8", 8'(sda_oe), 8'd0, "released after stop");

      // R10: read two registers, master ACK ignored (R7)
      rd_reg(8'h40, 1'b1, d);
      chk("R10", d, exp_regs[8'h40], "read data 0x40");
      bit_rd(a); chk("R7", 8'(a), 8'd1, "master ack ignored, SDA released");
      do_stop();
      rd_reg(8'h12, 1'b0, d);
      chk("R8", d, exp_regs[8'h12], "read after aborted write");
      do_stop();
      rd_reg(8'h07, 1'b0, d);
      chk("R10", d, exp_regs[8'h07], "read untouched register 0x07");
      do_stop();

      tick(20);
      chk("R9", 8'(drive_viol), 8'd0, "slave drove while master owned SDA");
      chk("R9", 8'(sda_oe), 8'd0, "idle release");
      chk("R11", 8'(wr_err), 8'd0, "write strobe mismatches");
      chk("R4", 8'(wq.size()), 8'd0, "expected writes still pending");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      tick(150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule